// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block lets a host read or write one 16-bit word of a 64-word serial EEPROM over a three-wire link. The link has a chip select, a serial clock and a data line toward the memory, plus a return data line from the memory. The host presents an operation (read or write), a 6-bit word address and, for a write, 16 bits of data, and pulses `start`. The block builds every command frame itself, drives the serial pins, and pulses `done` when the transfer is over. After a read, the word is on `rdata`. After a write, `timeout_err` shows whether the memory failed to report ready in time.

Every serial bit takes three phases of `PHASE_CYC` clock cycles each: clock low with the data set up, clock high, and clock low again. Each frame starts with chip select low for one phase. Chip select then rises and a clocked 0 bit goes out ahead of the start bit. A write is preceded by its own write-enable frame. After the write frame, chip select drops for one phase and rises again. The block then samples the memory's return line once every `POLL_CYC` cycles, for at most `POLL_MAX` samples.

States: IDLE (waiting, pins quiet), GAP (chip select low for one phase before a frame), SHIFT (frame bits going out), RECV (16 read bits coming in), DROP (chip select low for one phase after the write frame), POLL (waiting for the ready level), DONE (one-cycle completion). Transitions:
- IDLE→GAP on `start`.
- GAP→SHIFT after one phase.
- SHIFT→GAP when the write-enable frame ends.
- SHIFT→RECV when the read frame ends.
- SHIFT→DROP when the write frame ends.
- RECV→DONE after the 16th bit.
- DROP→POLL after one phase.
- POLL→DONE on a high sample or on the last allowed sample.
- DONE→IDLE always.

Top module: `mw_eeprom_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `ee_cs`, `ee_sclk`, `ee_mosi`, `busy` and `done` are all 0.
- R2: Before every frame, `ee_cs` is low for at least one phase (exactly `PHASE_CYC` cycles between two frames of the same operation). The first clocked bit of each frame is 0, and the second is the start bit 1.
- R3: A read sends the 10-bit frame 0,1,1,0 followed by the 6 address bits MSB first. It then gives 16 more clocks and samples `ee_miso` at the end of each clock-high phase. The bits are assembled MSB first into `rdata`, which is valid when `done` pulses.
- R4: Every write is preceded by a separate chip-select frame carrying the 10 bits 0,1,0,0,1,1,1,1,1,1 (write enable).
- R5: The write frame is 26 bits: 0,1,0,1, then the 6 address bits MSB first, then the 16 data bits MSB first.
- R6: `ee_mosi` changes only while `ee_sclk` is low. It is stable across every clock-high phase and through the cycle in which the clock falls.
- R7: After the write frame, `ee_cs` is low for one phase and then high with `ee_sclk` low. `ee_miso` is sampled every `POLL_CYC` cycles. The first high sample ends the operation with `timeout_err` = 0.
- R8: If `POLL_MAX` consecutive samples are all low, the operation ends with `timeout_err` = 1 after `POLL_MAX`·`POLL_CYC` cycles of chip select high. The flag is cleared when the next operation is accepted.
- R9: Every clock-high phase on `ee_sclk` lasts exactly `PHASE_CYC` cycles.
- R10: `busy` rises in the cycle after an accepted `start` and stays high until the single-cycle `done` pulse. `ee_cs` is low after `done`. A `start` while `busy` is high is ignored: no extra frame, no change to the running operation.
- R11: `ee_sclk` is high only while `ee_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled only in IDLE |
| op_write | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Word address |
| wdata | input | 16 | Word to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |
| timeout_err | output | 1 | Ready poll expired on the last write |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sclk | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to memory |
| ee_miso | input | 1 | Serial data / ready from memory |

## Verification
The hardest case to reach from the ports is the ready-poll timeout. The memory must hold its return line low for the whole window of `POLL_MAX` samples and then recover, so that the next operation can show the flag was cleared. The bench's behavioural memory has a programmable busy time after each write. For the timeout test this time is set just longer than the poll window. The bench then measures how long chip select stays high during the poll. Ignoring a `start` while busy is reached by pulsing a conflicting write request in the middle of a read. The frame log and a later read-back then show that nothing else happened.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_SHIFT,
        S_RECV,
        S_DROP,
        S_POLL,
        S_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        K_WEN,
        K_RD,
        K_WR
    } mw_kind_e;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int FW    = 4 + ADDR_W + DATA_W,
    localparam int BCW   = $clog2(FW + 1)
) (
    input  mw_kind_e          kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [FW-1:0]     vec,
    output logic [BCW-1:0]    len
);
    // Frames are left aligned: the first bit on the wire is vec[FW-1].
    always_comb begin
        unique case (kind)
            K_WEN: begin
                vec = {2'b01, 2'b00, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
                len = BCW'(4 + ADDR_W);
            end
            K_RD: begin
                vec = {2'b01, 2'b10, addr, {DATA_W{1'b0}}};
                len = BCW'(4 + ADDR_W);
            end
            default: begin
                vec = {2'b01, 2'b01, addr, data};
                len = BCW'(FW);
            end
        endcase
    end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int PHASE_CYC = 200,
    parameter int POLL_CYC  = 200000,
    parameter int POLL_MAX  = 100,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_err,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_mosi,
    input  logic              ee_miso
);
    localparam int FW  = 4 + ADDR_W + DATA_W;
    localparam int BCW = $clog2(FW + 1);
    localparam int RCW = $clog2(DATA_W + 1);
    localparam int PCW = $clog2(POLL_MAX + 1);

    mw_state_e         st, st_nx;
    logic [1:0]        ph;
    logic [FW-1:0]     shreg;
    logic [BCW-1:0]    bitcnt, bitlen;
    logic [RCW-1:0]    rcnt;
    logic [PCW-1:0]    pcnt;
    logic              is_wr, in_wen;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              ph_tick, poll_tick;
    logic              bit_end, frame_end, recv_end, poll_last;

    mw_kind_e          f_kind;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic [FW-1:0]     f_vec;
    logic [BCW-1:0]    f_len;

    mw_tick_gen #(.DIV(PHASE_CYC)) u_phase (
        .clk (clk), .rst_n (rst_n), .en (st != S_IDLE), .tick (ph_tick)
    );

    mw_tick_gen #(.DIV(POLL_CYC)) u_poll (
        .clk (clk), .rst_n (rst_n), .en (st == S_POLL), .tick (poll_tick)
    );

    always_comb begin
        if (st == S_IDLE) begin
            f_kind = op_write ? K_WEN : K_RD;
            f_addr = addr;
            f_data = wdata;
        end else begin
            f_kind = K_WR;
            f_addr = a_q;
            f_data = d_q;
        end
    end

    mw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .kind (f_kind), .addr (f_addr), .data (f_data), .vec (f_vec), .len (f_len)
    );

    assign bit_end   = ph_tick && (ph == 2'd2);
    assign frame_end = bit_end && (bitcnt == bitlen - BCW'(1));
    assign recv_end  = bit_end && (rcnt == RCW'(DATA_W - 1));
    assign poll_last = pcnt == PCW'(POLL_MAX - 1);

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_GAP;
            S_GAP:   if (ph_tick) st_nx = S_SHIFT;
            S_SHIFT: if (frame_end) st_nx = in_wen ? S_GAP : (is_wr ? S_DROP : S_RECV);
            S_RECV:  if (recv_end) st_nx = S_DONE;
            S_DROP:  if (ph_tick) st_nx = S_POLL;
            S_POLL:  if (poll_tick && (ee_miso || poll_last)) st_nx = S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Datapath: shift register, phase and bit counters, read accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph          <= '0;
            shreg       <= '0;
            bitcnt      <= '0;
            bitlen      <= '0;
            rcnt        <= '0;
            pcnt        <= '0;
            is_wr       <= 1'b0;
            in_wen      <= 1'b0;
            a_q         <= '0;
            d_q         <= '0;
            rdata       <= '0;
            timeout_err <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    is_wr       <= op_write;
                    in_wen      <= op_write;
                    a_q         <= addr;
                    d_q         <= wdata;
                    shreg       <= f_vec;
                    bitlen      <= f_len;
                    bitcnt      <= '0;
                    ph          <= '0;
                    rcnt        <= '0;
                    pcnt        <= '0;
                    timeout_err <= 1'b0;
                end
                S_SHIFT: if (ph_tick) begin
                    if (ph == 2'd2) begin
                        ph <= '0;
                        if (frame_end && in_wen) begin
                            in_wen <= 1'b0;
                            shreg  <= f_vec;
                            bitlen <= f_len;
                            bitcnt <= '0;
                        end else begin
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt + BCW'(1);
                        end
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                S_RECV: if (ph_tick) begin
                    if (ph == 2'd1) rdata <= {rdata[DATA_W-2:0], ee_miso};
                    if (ph == 2'd2) begin
                        ph   <= '0;
                        rcnt <= rcnt + RCW'(1);
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                S_POLL: if (poll_tick) begin
                    pcnt <= pcnt + PCW'(1);
                    if (!ee_miso && poll_last) timeout_err <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (st != S_IDLE);
        done    = (st == S_DONE);
        ee_cs   = (st == S_SHIFT) || (st == S_RECV) || (st == S_POLL);
        ee_sclk = ((st == S_SHIFT) || (st == S_RECV)) && (ph == 2'd1);
        ee_mosi = (st == S_SHIFT) && shreg[FW-1];
    end
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk #(
    parameter int PHASE_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic ee_cs,
    input logic ee_sclk,
    input logic ee_mosi
);
    int hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= 0;
        else if (ee_sclk) hi_run <= hi_run + 1;
        else              hi_run <= 0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sclk && !ee_mosi && !done));

    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ee_sclk) |-> $stable(ee_mosi));

    assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);

    assert_high_phase_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_sclk && $past(ee_sclk)) |-> (hi_run == PHASE_CYC));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && !ee_cs));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_sclk_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> ee_cs);
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .ee_cs       (ee_cs),
    .ee_sclk     (ee_sclk),
    .ee_mosi     (ee_mosi)
);

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb;
    localparam int PH = 2;
    localparam int PC = 16;
    localparam int PM = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, timeout_err, ee_cs, ee_sclk, ee_mosi;
    logic [15:0] rdata;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mw_eeprom_master #(.PHASE_CYC(PH), .POLL_CYC(PC), .POLL_MAX(PM)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .op_write (op_write),
        .addr (addr), .wdata (wdata), .busy (busy), .done (done),
        .rdata (rdata), .timeout_err (timeout_err), .ee_cs (ee_cs),
        .ee_sclk (ee_sclk), .ee_mosi (ee_mosi), .ee_miso (miso)
    );

    // Behavioural memory, sampled on the system clock
    logic [15:0] mem [64];
    logic        cs_p = 0, sclk_p = 0, mosi_p = 0, wen = 0, rd_mode = 0;
    logic [31:0] fbits = 0;
    int          nbits = 0, lo_run = 0, cshi = 0, gap = 0, shi = 0;
    int          rd_k = 0, rdy_cnt = 0, rdy_dly = 40, mosi_viol = 0;
    int          shi_min = 1000, shi_max = 0;
    logic [5:0]  rd_addr = 0;
    logic [31:0] log_bits [8];
    int          log_len [8], log_gap [8], log_hi [8];
    int          nlog = 0;

    always @(posedge clk) begin
        cyc++;
        if (rdy_cnt > 0) rdy_cnt--;
        if (ee_sclk) shi++;
        else begin
            if (sclk_p) begin
                if (shi < shi_min) shi_min = shi;
                if (shi > shi_max) shi_max = shi;
            end
            shi = 0;
        end
        if (sclk_p && ee_mosi != mosi_p) mosi_viol++;
        if (ee_cs && !cs_p) begin
            nbits = 0; fbits = 0; gap = lo_run; cshi = 0; rd_mode = 0;
        end
        if (ee_cs) begin cshi++; lo_run = 0; end
        else lo_run++;
        if (ee_sclk && !sclk_p && ee_cs) begin
            if (rd_mode) begin
                miso <= mem[rd_addr][15-rd_k];
                rd_k++;
            end else begin
                fbits = {fbits[30:0], ee_mosi};
                nbits++;
                if (nbits == 10 && fbits[9:6] == 4'b0110) begin
                    rd_mode = 1; rd_addr = fbits[5:0]; rd_k = 0;
                end
            end
        end
        if (!ee_cs && cs_p) begin
            if (nlog < 8) begin
                log_bits[nlog] = fbits; log_len[nlog] = nbits;
                log_gap[nlog] = gap; log_hi[nlog] = cshi;
            end
            nlog++;
            if (nbits == 10 && fbits[9:0] == 10'b0100111111) wen = 1;
            else if (nbits == 26 && fbits[25:22] == 4'b0101) begin
                if (wen) mem[fbits[21:16]] = fbits[15:0];
                wen = 0;
                rdy_cnt = rdy_dly;
            end
            rd_mode = 0;
        end
        if (!rd_mode) miso <= ee_cs && (rdy_cnt == 0);
        cs_p = ee_cs; sclk_p = ee_sclk; mosi_p = ee_mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h0421) ^ 16'hA55A;
    endfunction

    logic        got_err;
    logic [15:0] got_data;

    task automatic run_op(input bit wr, input logic [5:0] a, input logic [15:0] d);
        int n;
        nlog = 0;
        @(negedge clk);
        start = 1; op_write = wr; addr = a; wdata = d;
        @(negedge clk);
        start = 0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        got_err = timeout_err;
        got_data = rdata;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!ee_cs && !ee_sclk && !ee_mosi && !busy && !done, "R1 reset idle",
            {ee_cs, ee_sclk, ee_mosi, busy, done}, 0);

        // R10: busy in cycle after start, done single pulse
        @(negedge clk);
        start = 1; op_write = 0; addr = 6'd1;
        @(negedge clk);
        start = 0;
        chk(busy, "R10 busy after start", busy, 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done && !busy && !ee_cs, "R10 done single pulse, cs low",
            {done, busy, ee_cs}, 0);

        // Write sweep over all addresses
        for (int a = 0; a < 64; a++) begin
            run_op(1, 6'(a), pat(a));
            chk(got_err == 0, "R7 write ok no timeout", got_err, 0);
            chk(nlog == 3, "R7 frame count of write", nlog, 3);
            chk(log_len[0] == 10 && log_bits[0][9:0] == 10'b0100111111,
                "R4 write-enable frame", log_bits[0][9:0], 10'b0100111111);
            chk(log_len[1] == 26 && log_bits[1][25:0] == {4'b0101, 6'(a), pat(a)},
                "R5 write frame", log_bits[1][25:0], {4'b0101, 6'(a), pat(a)});
            chk(log_gap[1] == PH, "R2 gap between frames", log_gap[1], PH);
            chk(log_len[2] == 0 && log_gap[2] == PH && log_hi[2] < PM * PC,
                "R7 drop then poll", log_gap[2], PH);
            chk(!ee_cs && !busy, "R10 idle after write", {ee_cs, busy}, 0);
        end

        // Read sweep
        for (int a = 0; a < 64; a++) begin
            run_op(0, 6'(a), 16'h0);
            chk(got_data == pat(a), "R3 read data", got_data, pat(a));
            chk(nlog == 1 && log_len[0] == 10 && log_bits[0][9:0] == {4'b0110, 6'(a)},
                "R3 read frame", log_bits[0][9:0], {4'b0110, 6'(a)});
            chk(log_gap[0] >= PH, "R2 gap before read frame", log_gap[0], PH);
        end

        // R9 / R6 waveform properties across the whole run
        chk(shi_min == PH && shi_max == PH, "R9 clock high length", shi_max, PH);
        chk(mosi_viol == 0, "R6 data stable while clock high", mosi_viol, 0);

        // R8 timeout: memory stays busy longer than the poll window
        rdy_dly = PM * PC + 60;
        run_op(1, 6'd5, 16'h0FF0);
        chk(got_err == 1, "R8 timeout flag set", got_err, 1);
        chk(log_hi[2] == PM * PC, "R8 poll window length", log_hi[2], PM * PC);
        rdy_dly = 40;
        repeat (100) @(negedge clk);
        run_op(0, 6'd5, 16'h0);
        chk(got_err == 0, "R8 flag cleared by next op", got_err, 0);
        chk(got_data == 16'h0FF0, "R3 read after timed-out write", got_data, 16'h0FF0);

        // R10: start while busy is ignored
        nlog = 0;
        @(negedge clk);
        start = 1; op_write = 0; addr = 6'd7;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        start = 1; op_write = 1; addr = 6'd7; wdata = 16'h0000;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        got_data = rdata;
        repeat (10) @(negedge clk);
        chk(got_data == pat(7), "R10 running read unaffected", got_data, pat(7));
        chk(nlog == 1 && !busy, "R10 no extra frame from ignored start", nlog, 1);
        run_op(0, 6'd7, 16'h0);
        chk(got_data == pat(7), "R10 memory not written by ignored start", got_data, pat(7));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule